// File: doc/BRIEF.md
# Eight-Channel DMA Request Arbiter

This block decides which of eight DMA channels may run the next single operand transfer. Each channel presents an active-low request pin. A per-channel mode bit selects how that pin is read. In level mode, a low pin means "request present". In edge mode, a falling edge raises one pending request, which is held until the channel is served. The arbiter drives one grant at a time and holds it until the transfer engine pulses `xfer_done`. It then picks the next winner. Channel 0 always beats channel 1, channel 1 beats channel 2, and so on down to channel 7.

A level-mode channel that has just been served is hidden from arbitration for a window. The window length is `mask_cycles`, a cycle count shared by all channels, and a per-channel down-counter times it. While hidden, the channel is treated as absent: a lower-priority channel may win, and if nothing else is requesting the arbiter stays idle. Edge-mode channels never get such a window. Request pins pass through a two-flop synchronizer before any sensing, so the pins may be asynchronous.

Top module: `dma_req_arbiter`

## Requirements
- R1: Among eligible channels, the lowest index wins. Channel 0 has the highest priority and channel 7 the lowest.
- R2: `grant` is one-hot while `busy` is 1. `grant_idx` is the index of the set grant bit. When `busy` is 0, `grant` is all zeros and `grant_idx` is 0.
- R3: Once issued, a grant does not change until `xfer_done` is seen, even if a higher-priority channel starts requesting.
- R4: Timing of a new grant:
  - From idle, a grant is visible after the third rising edge following a change at a request pin.
  - The rising edge that samples `xfer_done` drops `busy` and `grant`.
  - The next rising edge issues the next grant, if any channel is eligible.
- R5: In level mode (`sense_edge[i]`=0), a low `req_n[i]` is a request and a high `req_n[i]` is none.
- R6: After a level-mode channel's transfer ends, that channel is ineligible for `mask_cycles` cycles. With mask value M and `xfer_done` sampled at edge E, the channel can be granted again at edge E+1+M at the earliest, even if no other channel requests.
- R7: A level-mode channel inside its window is treated as absent, so a lower-priority requesting channel is granted instead.
- R8: In edge mode (`sense_edge[i]`=1), each falling edge of `req_n[i]` yields exactly one grant. A pin held low afterwards yields nothing more.
- R9: A falling edge that arrives during the channel's own transfer is kept. The channel is granted again at the first decision after `xfer_done`, with no window, whatever the value of `mask_cycles`.
- R10: Any number of falling edges seen before the channel is granted merge into a single pending request.
- R11: After reset, `grant` is 0, `grant_idx` is 0 and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | NUM_CH | Active-low request pins, may be asynchronous |
| sense_edge | input | NUM_CH | Per channel: 1 = falling-edge mode, 0 = level mode |
| mask_cycles | input | MASK_W | Post-service window length for level-mode channels, in cycles |
| xfer_done | input | 1 | One-cycle pulse from the transfer engine at the end of an operand transfer |
| grant | output | NUM_CH | One-hot grant, registered |
| grant_idx | output | $clog2(NUM_CH) | Index of the granted channel, registered |
| busy | output | 1 | High while a grant is outstanding |

## Verification
A change at a request pin reaches a grant from idle on the third rising edge: two synchronizer edges, then the registered decision. After `xfer_done` is sampled, outputs drop on that same edge and the next grant follows one edge later. A level channel that has just been served returns M edges after that. The bench drives and samples only on falling edges and counts those edges from each stimulus. It samples one edge before each due point to see that nothing arrives early, and again at the due point. It also samples several cycles into a hold to confirm that nothing changes.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    SENSE_LEVEL = 1'b0,
    SENSE_FALL  = 1'b1
  } sense_t;

  localparam int unsigned DEF_CHANNELS = 8;
  localparam int unsigned DEF_MASK_W   = 8;
endpackage

// File: rtl/dma_req_front.sv
module dma_req_front #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req_n,
  input  logic [NUM_CH-1:0] sense_edge,
  input  logic [NUM_CH-1:0] take,
  output logic [NUM_CH-1:0] want
);
  import dma_arb_pkg::*;

  logic [NUM_CH-1:0] meta_q, sync_q, prev_q, pend_q;

  // two-flop synchronizer plus delayed copy for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '1;
      sync_q <= '1;
      prev_q <= '1;
    end else begin
      meta_q <= req_n;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic fall;
    assign fall = prev_q[c] & ~sync_q[c];

    // pending edge request: merges repeated edges, cleared when granted
    always_ff @(posedge clk) begin
      if (rst) pend_q[c] <= 1'b0;
      else     pend_q[c] <= (sense_t'(sense_edge[c]) == SENSE_FALL) &&
                            ((pend_q[c] | fall) & ~take[c]);
    end

    always_comb begin
      if (sense_t'(sense_edge[c]) == SENSE_FALL) want[c] = pend_q[c] | fall;
      else                                       want[c] = ~sync_q[c];
    end
  end
endmodule

// File: rtl/dma_mask_timers.sv
module dma_mask_timers #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned MASK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] load,
  input  logic [MASK_W-1:0] mask_cycles,
  output logic [NUM_CH-1:0] masked
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_tmr
    logic [MASK_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
      if (rst)                cnt_q <= '0;
      else if (load[c])       cnt_q <= mask_cycles;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign masked[c] = (cnt_q != '0);
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [NUM_CH-1:0] elig,
  output logic              any,
  output logic [NUM_CH-1:0] win_oh,
  output logic [IDX_W-1:0]  win_idx
);
  // scan from the lowest priority upward so the lowest index overwrites
  always_comb begin
    win_oh  = '0;
    win_idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        win_oh    = '0;
        win_oh[i] = 1'b1;
        win_idx   = IDX_W'(i);
      end
    end
  end

  assign any = |elig;
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int unsigned NUM_CH = dma_arb_pkg::DEF_CHANNELS,
  parameter int unsigned MASK_W = dma_arb_pkg::DEF_MASK_W,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req_n,
  input  logic [NUM_CH-1:0] sense_edge,
  input  logic [MASK_W-1:0] mask_cycles,
  input  logic              xfer_done,
  output logic [NUM_CH-1:0] grant,
  output logic [IDX_W-1:0]  grant_idx,
  output logic              busy
);
  logic [NUM_CH-1:0] want, masked, elig, win_oh, take, load;
  logic [IDX_W-1:0]  win_idx;
  logic              any, issue, finish;

  assign issue  = ~busy & any;
  assign finish = busy & xfer_done;
  assign take   = issue ? win_oh : '0;
  assign load   = finish ? (grant & ~sense_edge) : '0;
  assign elig   = want & ~masked;

  dma_req_front #(.NUM_CH(NUM_CH)) front_i (
    .clk(clk), .rst(rst), .req_n(req_n), .sense_edge(sense_edge),
    .take(take), .want(want)
  );

  dma_mask_timers #(.NUM_CH(NUM_CH), .MASK_W(MASK_W)) mask_i (
    .clk(clk), .rst(rst), .load(load), .mask_cycles(mask_cycles),
    .masked(masked)
  );

  dma_prio_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) pick_i (
    .elig(elig), .any(any), .win_oh(win_oh), .win_idx(win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      grant     <= '0;
      grant_idx <= '0;
    end else if (finish) begin
      busy      <= 1'b0;
      grant     <= '0;
      grant_idx <= '0;
    end else if (issue) begin
      busy      <= 1'b1;
      grant     <= win_oh;
      grant_idx <= win_idx;
    end
  end

  // R2: at most one grant bit, and the index matches it while busy
  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && (busy == (grant != '0)));
  assert_idx_match_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> grant[grant_idx]);
  // R3: no change of grant until the transfer ends
  assert_no_preempt_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !xfer_done) |=> (busy && $stable(grant)));
  // R4: done releases the grant on the next edge
  assert_release_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && xfer_done) |=> !busy);
  // R1: nothing of higher priority than the winner was eligible
  assert_fixed_prio_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy && (elig != '0)) |=> (busy && (($past(elig) & (grant - 1'b1)) == '0)));
  // R7: a masked channel is never granted
  assert_mask_hides_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |=> ((grant & $past(masked)) == '0));
endmodule

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] req_n = '1;
  logic [NCH-1:0] sense_edge = '0;
  logic [7:0]     mask_cycles = '0;
  logic           xfer_done = 1'b0;
  logic [NCH-1:0] grant;
  logic [2:0]     grant_idx;
  logic           busy;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_arbiter #(.NUM_CH(NCH), .MASK_W(8)) dut_i (
    .clk(clk), .rst(rst), .req_n(req_n), .sense_edge(sense_edge),
    .mask_cycles(mask_cycles), .xfer_done(xfer_done),
    .grant(grant), .grant_idx(grant_idx), .busy(busy)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_grant(input string tag, input int ch);
    if (ch < 0) begin
      chk({tag, " grant"}, int'(grant), 0);
      chk({tag, " busy"}, int'(busy), 0);
    end else begin
      chk({tag, " grant"}, int'(grant), 1 << ch);
      chk({tag, " idx"}, int'(grant_idx), ch);
      chk({tag, " busy"}, int'(busy), 1);
    end
  endtask

  // leaves the bench at the falling edge after the sampling rising edge
  task automatic pulse_done();
    xfer_done = 1'b1;
    step(1);
    xfer_done = 1'b0;
  endtask

  task automatic test_reset();
    expect_grant("R11 reset", -1);
    chk("R11 reset idx", int'(grant_idx), 0);
  endtask

  task automatic test_level_mask();
    mask_cycles = 8'd4;
    req_n[3] = 1'b0;
    step(2);
    expect_grant("R4 early", -1);
    step(1);
    expect_grant("R5 level grant", 3);
    step(5);
    expect_grant("R3 hold", 3);
    pulse_done();
    expect_grant("R4 release", -1);
    step(4);
    expect_grant("R6 still masked alone", -1);
    step(1);
    expect_grant("R6 regrant after window", 3);
    req_n[3] = 1'b1;
    step(3);
    pulse_done();
    step(10);
    expect_grant("R5 high means none", -1);
  endtask

  task automatic test_priority();
    mask_cycles = 8'd0;
    req_n[5] = 1'b0;
    step(3);
    expect_grant("R5 ch5", 5);
    req_n[1] = 1'b0;
    req_n[6] = 1'b0;
    step(5);
    expect_grant("R3 no preempt", 5);
    pulse_done();
    step(1);
    expect_grant("R1 ch1 wins", 1);
    req_n[1] = 1'b1;
    step(3);
    pulse_done();
    step(1);
    expect_grant("R1 ch5 resumes", 5);
    req_n[5] = 1'b1;
    step(3);
    pulse_done();
    step(1);
    expect_grant("R1 ch6 last", 6);
    req_n[6] = 1'b1;
    step(3);
    pulse_done();
    step(1);
    expect_grant("R4 idle after all", -1);
  endtask

  task automatic test_mask_hides();
    mask_cycles = 8'd6;
    req_n[2] = 1'b0;
    req_n[4] = 1'b0;
    step(3);
    expect_grant("R1 ch2 first", 2);
    pulse_done();
    step(1);
    expect_grant("R7 masked ch2 skipped", 4);
    pulse_done();
    step(1);
    expect_grant("R6 both masked", -1);
    step(3);
    expect_grant("R6 ch2 window open", -1);
    step(1);
    expect_grant("R6 ch2 back", 2);
    req_n[2] = 1'b1;
    req_n[4] = 1'b1;
    step(3);
    pulse_done();
    step(12);
    expect_grant("R5 quiet", -1);
  endtask

  task automatic test_edge();
    mask_cycles = 8'd5;
    sense_edge[6] = 1'b1;
    step(2);
    req_n[6] = 1'b0;
    step(2);
    expect_grant("R4 edge early", -1);
    step(1);
    expect_grant("R8 edge grant", 6);
    pulse_done();
    step(1);
    expect_grant("R8 held low no regrant", -1);
    step(3);
    expect_grant("R8 still none", -1);
    req_n[6] = 1'b1;
    step(3);
    req_n[6] = 1'b0;
    step(3);
    expect_grant("R8 new edge grant", 6);
    req_n[6] = 1'b1;
    step(2);
    req_n[6] = 1'b0;
    step(3);
    req_n[6] = 1'b1;
    step(2);
    req_n[6] = 1'b0;
    step(3);
    expect_grant("R3 edge own transfer hold", 6);
    pulse_done();
    step(1);
    expect_grant("R9 latched edge no mask", 6);
    pulse_done();
    step(1);
    expect_grant("R10 edges merged", -1);
    step(3);
    expect_grant("R10 stays idle", -1);
    req_n[6] = 1'b1;
    sense_edge[6] = 1'b0;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    test_reset();
    test_level_mask();
    test_priority();
    test_mask_hides();
    test_edge();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R4 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule